// File: doc/BRIEF.md
# Two-Dimensional DMA Address Generator

This block produces the byte-address sequence for one DMA channel. Software sets the channel up through parallel configuration inputs: a base address, an element size, an inner element count with a signed inner step, and an outer row count with a signed outer step. A one-cycle `start` pulse copies these settings into the block. The block then presents one address at a time with `addr_valid`. The data mover accepts each address by raising `advance`, and the block moves on to the next address. Within a row, the address moves by the inner step. At the end of each row it moves by the outer step instead. Because the outer step may be smaller than the inner step, or negative, one pass can walk an interleaved buffer in de-interleaved order.

The controller has three states. `ST_IDLE` waits for `start`. `ST_RUN` presents addresses. `ST_RELOAD` is a single gap cycle used only in circular mode. The transitions are:
- `ST_IDLE`→`ST_RUN` when `start` is high.
- `ST_RUN`→`ST_RUN` on every accepted element except the final one.
- `ST_RUN`→`ST_IDLE` after the final element in single-buffer mode.
- `ST_RUN`→`ST_RELOAD` after the final element in circular mode.
- `ST_RELOAD`→`ST_RUN` unconditionally, reloading the base address and both counts.

A completion pulse marks the end of every buffer. A fractional pulse marks the end of each row, or a chosen remaining-count point in linear transfers.

Top module: `dma2d_addr_gen`

## Requirements
- R1: While reset is asserted and afterwards until `start`, `addr_valid`, `busy`, `irq_done` and `irq_frac` are all low.
- R2: A `start` pulse in `ST_IDLE` makes `addr_valid` high with `addr` equal to `cfg_base` on the following cycle. `start` and all configuration inputs are ignored while the block is busy.
- R3: Within a row, each accepted element adds the sign-extended inner step times the element size to `addr`. `cfg_esize` encodes the element size as 0 = 1 byte, 1 = 2 bytes, and 2 or 3 = 4 bytes.
- R4: In two-dimensional mode (`cfg_two_d`=1), accepting the last element of a row adds the sign-extended outer step times the element size instead, and the inner count starts again. The outer step may be smaller than the inner step, or negative.
- R5: In one-dimensional mode (`cfg_two_d`=0), the transfer has exactly one row, and `cfg_ocnt` and `cfg_ostep` have no effect.
- R6: An inner or outer count of zero means 65536.
- R7: In single-buffer mode (`cfg_auto`=0), `irq_done` pulses for one cycle in the cycle after the final element is accepted. In that same cycle `addr_valid` is low and the block is back in `ST_IDLE`.
- R8: In circular mode (`cfg_auto`=1), `irq_done` pulses after each buffer. `addr_valid` is low for that one cycle, and on the next cycle it is high again with `addr` equal to the base address.
- R9: In two-dimensional mode, `irq_frac` pulses for one cycle after the last element of every row except the final row.
- R10: In one-dimensional mode, `irq_frac` pulses for one cycle after the element that leaves exactly `cfg_frac_thr` elements remaining. A threshold of zero disables this pulse.
- R11: While `advance` is low in `ST_RUN`, `addr` and `addr_valid` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer from `ST_IDLE` |
| cfg_base | input | 32 | Starting byte address |
| cfg_icnt | input | 16 | Elements per row (0 = 65536) |
| cfg_istep | input | 16 | Signed inner step in elements |
| cfg_ocnt | input | 16 | Row count (0 = 65536) |
| cfg_ostep | input | 16 | Signed outer step in elements |
| cfg_two_d | input | 1 | 1 = two-dimensional walk |
| cfg_auto | input | 1 | 1 = circular restart |
| cfg_esize | input | 2 | Element size code |
| cfg_frac_thr | input | 16 | Remaining-count point for the linear fractional pulse |
| advance | input | 1 | Data mover accepts the current address |
| addr | output | 32 | Current byte address |
| addr_valid | output | 1 | `addr` is valid for use |
| busy | output | 1 | Block is not in `ST_IDLE` |
| irq_done | output | 1 | Buffer-complete pulse |
| irq_frac | output | 1 | Fractional-progress pulse |

## Verification
The assertions check four properties on every cycle:
- The address and its valid flag hold during a stall.
- A completion pulse always follows an accepted address and leaves the valid flag low.
- A circular restart shows the base address one cycle after completion.
- The two interrupts never coincide, and no counter is decremented past its final element.

The exact address sequence can only be shown by the bench scenarios. These scenarios cover the inner and outer steps, negative and interleaving strides, all element sizes, the position of each fractional pulse, the 65536-element case, and whether `start` is ignored mid-transfer.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_RELOAD = 2'd2
    } dma_state_t;
endpackage

// File: rtl/dma2d_step.sv
module dma2d_step #(
    parameter int STEP_W = 16,
    parameter int ADDR_W = 32
) (
    input  logic [STEP_W-1:0] step,
    input  logic [1:0]        esz,
    output logic [ADDR_W-1:0] delta
);
    localparam int EXT_W = ADDR_W - STEP_W;

    logic [ADDR_W-1:0] sx;

    assign sx = {{EXT_W{step[STEP_W-1]}}, step};

    // Scale the element step to bytes: 1, 2 or 4 bytes per element.
    always_comb begin
        unique case (esz)
            2'd0:    delta = sx;
            2'd1:    delta = sx << 1;
            default: delta = sx << 2;
        endcase
    end
endmodule

// File: rtl/dma2d_cnt.sv
module dma2d_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W:0]   cnt,
    output logic             last
);
    localparam logic [CNT_W:0] FULL = {1'b1, {CNT_W{1'b0}}};

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= (load_val == '0) ? FULL : {1'b0, load_val};
        else if (dec)
            cnt <= cnt - 1'b1;
    end

    assign last = (cnt == {{CNT_W{1'b0}}, 1'b1});

    // R6
    dec_above_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> (cnt > {{CNT_W{1'b0}}, 1'b1}));

    // R4
    no_load_dec_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && dec));
endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen
    import dma2d_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int STEP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [CNT_W-1:0]  cfg_icnt,
    input  logic [STEP_W-1:0] cfg_istep,
    input  logic [CNT_W-1:0]  cfg_ocnt,
    input  logic [STEP_W-1:0] cfg_ostep,
    input  logic              cfg_two_d,
    input  logic              cfg_auto,
    input  logic [1:0]        cfg_esize,
    input  logic [CNT_W-1:0]  cfg_frac_thr,
    input  logic              advance,
    output logic [ADDR_W-1:0] addr,
    output logic              addr_valid,
    output logic              busy,
    output logic              irq_done,
    output logic              irq_frac
);
    localparam int CW1 = CNT_W + 1;
    localparam logic [CNT_W-1:0] ONE_ROW = {{(CNT_W-1){1'b0}}, 1'b1};

    dma_state_t state, nxt;

    logic [ADDR_W-1:0] base_r;
    logic [CNT_W-1:0]  icnt_r, ocnt_r, thr_r;
    logic [STEP_W-1:0] istep_r, ostep_r;
    logic [1:0]        esz_r;
    logic              two_d_r, auto_r;

    logic [ADDR_W-1:0] idelta, odelta;
    logic [CW1-1:0]    i_cnt, o_cnt;
    logic              i_last, o_last;
    logic              launch, fire, row_end, xfer_end;
    logic              i_load, i_dec, o_load, o_dec;
    logic [CNT_W-1:0]  i_val, o_val;

    assign launch   = (state == ST_IDLE) && start;
    assign fire     = (state == ST_RUN) && advance;
    assign row_end  = fire && i_last;
    assign xfer_end = row_end && o_last;

    assign i_load = launch || (state == ST_RELOAD) || (row_end && !o_last);
    assign i_dec  = fire && !i_last;
    assign i_val  = launch ? cfg_icnt : icnt_r;
    assign o_load = launch || (state == ST_RELOAD);
    assign o_dec  = row_end && !o_last;
    assign o_val  = launch ? (cfg_two_d ? cfg_ocnt : ONE_ROW)
                           : (two_d_r ? ocnt_r : ONE_ROW);

    dma2d_cnt #(.CNT_W(CNT_W)) u_inner (
        .clk(clk), .rst_n(rst_n), .load(i_load), .load_val(i_val),
        .dec(i_dec), .cnt(i_cnt), .last(i_last)
    );

    dma2d_cnt #(.CNT_W(CNT_W)) u_outer (
        .clk(clk), .rst_n(rst_n), .load(o_load), .load_val(o_val),
        .dec(o_dec), .cnt(o_cnt), .last(o_last)
    );

    dma2d_step #(.STEP_W(STEP_W), .ADDR_W(ADDR_W)) u_istep (
        .step(istep_r), .esz(esz_r), .delta(idelta)
    );

    dma2d_step #(.STEP_W(STEP_W), .ADDR_W(ADDR_W)) u_ostep (
        .step(ostep_r), .esz(esz_r), .delta(odelta)
    );

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (start) nxt = ST_RUN;
            ST_RUN:    if (xfer_end) nxt = auto_r ? ST_RELOAD : ST_IDLE;
            ST_RELOAD: nxt = ST_RUN;
            default:   nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Configuration capture at launch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_r  <= '0; icnt_r  <= '0; ocnt_r <= '0; thr_r <= '0;
            istep_r <= '0; ostep_r <= '0; esz_r  <= '0;
            two_d_r <= 1'b0; auto_r <= 1'b0;
        end else if (launch) begin
            base_r  <= cfg_base;  icnt_r  <= cfg_icnt;  ocnt_r <= cfg_ocnt;
            thr_r   <= cfg_frac_thr;
            istep_r <= cfg_istep; ostep_r <= cfg_ostep; esz_r  <= cfg_esize;
            two_d_r <= cfg_two_d; auto_r  <= cfg_auto;
        end
    end

    // Output process: address walk and interrupt pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr     <= '0;
            irq_done <= 1'b0;
            irq_frac <= 1'b0;
        end else begin
            irq_done <= xfer_end;
            if (two_d_r)
                irq_frac <= row_end && !o_last;
            else
                irq_frac <= i_dec && (thr_r != '0) &&
                            ((i_cnt - 1'b1) == {1'b0, thr_r});
            if (launch)
                addr <= cfg_base;
            else if (state == ST_RELOAD)
                addr <= base_r;
            else if (i_dec)
                addr <= addr + idelta;
            else if (o_dec)
                addr <= addr + odelta;
        end
    end

    assign addr_valid = (state == ST_RUN);
    assign busy       = (state != ST_IDLE);

    // R11
    hold_while_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && !advance) |=> (addr_valid && $stable(addr)));

    // R7
    done_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done |-> (!addr_valid && $past(addr_valid && advance)));

    // R8
    auto_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_done && auto_r) |=> (addr_valid && addr == base_r));

    // R9
    irq_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_done && irq_frac));
endmodule

// File: tb/sim_dma2d_addr_gen.sv
module sim_dma2d_addr_gen;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [31:0] base;
        logic [15:0] icnt;
        logic [15:0] istep;
        logic [15:0] ocnt;
        logic [15:0] ostep;
        logic        two_d;
        logic [1:0]  esz;
        logic [15:0] thr;
    } vec_t;

    // base, icnt, istep, ocnt, ostep, two_d, esz, thr
    localparam vec_t VECS [0:4] = '{
        '{32'h0000_1000, 16'd5, 16'd1,      16'd0, 16'd0,      1'b0, 2'd2, 16'd2}, // R3 R10
        '{32'h0000_2000, 16'd3, 16'd4,      16'd4, 16'hFFF9,   1'b1, 2'd0, 16'd0}, // R4 R9 interleave
        '{32'h0000_0100, 16'd2, 16'hFFFF,   16'd3, 16'd5,      1'b1, 2'd1, 16'd0}, // R4 R9 negative inner
        '{32'h0000_3000, 16'd4, 16'd3,      16'd9, 16'd100,    1'b0, 2'd3, 16'd0}, // R5 R3
        '{32'hFFFF_FFF0, 16'd1, 16'd7,      16'd0, 16'd0,      1'b0, 2'd0, 16'd0}  // R7
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] cfg_base = '0;
    logic [15:0] cfg_icnt = '0, cfg_istep = '0, cfg_ocnt = '0, cfg_ostep = '0;
    logic        cfg_two_d = 1'b0, cfg_auto = 1'b0;
    logic [1:0]  cfg_esize = '0;
    logic [15:0] cfg_frac_thr = '0;
    logic        advance = 1'b0;
    logic [31:0] addr;
    logic        addr_valid, busy, irq_done, irq_frac;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma2d_addr_gen u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_base(cfg_base),
        .cfg_icnt(cfg_icnt), .cfg_istep(cfg_istep), .cfg_ocnt(cfg_ocnt),
        .cfg_ostep(cfg_ostep), .cfg_two_d(cfg_two_d), .cfg_auto(cfg_auto),
        .cfg_esize(cfg_esize), .cfg_frac_thr(cfg_frac_thr), .advance(advance),
        .addr(addr), .addr_valid(addr_valid), .busy(busy),
        .irq_done(irq_done), .irq_frac(irq_frac)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apply_cfg(input vec_t v, input bit auto_mode);
        cfg_base = v.base;  cfg_icnt = v.icnt;  cfg_istep = v.istep;
        cfg_ocnt = v.ocnt;  cfg_ostep = v.ostep; cfg_two_d = v.two_d;
        cfg_esize = v.esz;  cfg_frac_thr = v.thr; cfg_auto = auto_mode;
    endtask

    function automatic int esz_bytes(input logic [1:0] e);
        return (e == 2'd0) ? 1 : (e == 2'd1) ? 2 : 4;
    endfunction

    // Walk one buffer with advance held high, starting at a negedge where
    // addr_valid is already expected high at the base address.
    task automatic walk(input vec_t v, input string req);
        int ni, no, sz, si, so;
        logic [31:0] a;
        bit prev_frac, first;
        ni = (v.icnt == 0) ? 65536 : int'(v.icnt);
        no = v.two_d ? ((v.ocnt == 0) ? 65536 : int'(v.ocnt)) : 1;
        sz = esz_bytes(v.esz);
        si = int'($signed(v.istep));
        so = int'($signed(v.ostep));
        a = v.base;
        prev_frac = 1'b0;
        first = 1'b1;
        for (int r = 0; r < no; r++) begin
            for (int c = 0; c < ni; c++) begin
                chk(addr_valid == 1'b1 && addr == a, req, addr, a);
                if (!first) begin
                    chk(irq_frac == prev_frac, "R9/R10 frac", 32'(irq_frac), 32'(prev_frac));
                    chk(irq_done == 1'b0, "R7 early done", 32'(irq_done), 32'd0);
                end
                first = 1'b0;
                if (v.two_d) prev_frac = (c == ni - 1) && (r != no - 1);
                else         prev_frac = (v.thr != 0) && ((ni - c - 1) == int'(v.thr));
                if (c != ni - 1) a = a + 32'(si * sz);
                else             a = a + 32'(so * sz);
                advance = 1'b1;
                @(negedge clk);
            end
        end
        chk(irq_frac == prev_frac, "R9/R10 last frac", 32'(irq_frac), 32'(prev_frac));
        chk(irq_done == 1'b1, "R7 done pulse", 32'(irq_done), 32'd1);
        chk(addr_valid == 1'b0, "R7 valid drop", 32'(addr_valid), 32'd0);
    endtask

    task automatic run_single(input vec_t v, input string req);
        apply_cfg(v, 1'b0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        walk(v, req);
        advance = 1'b0;
        @(negedge clk);
        chk(irq_done == 1'b0, "R7 single pulse", 32'(irq_done), 32'd0);
        chk(busy == 1'b0, "R7 idle", 32'(busy), 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        vec_t v;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(addr_valid == 1'b0 && busy == 1'b0, "R1 reset valid", {30'd0, addr_valid, busy}, 32'd0);
        chk(irq_done == 1'b0 && irq_frac == 1'b0, "R1 reset irq", {30'd0, irq_done, irq_frac}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(addr_valid == 1'b0, "R1 idle after reset", 32'(addr_valid), 32'd0);

        // Table-driven transfers
        for (int i = 0; i < 5; i++) begin
            run_single(VECS[i], "R2/R3/R4/R5 address");
        end

        // R11 and R2: stall and start ignored while busy
        v = '{32'h0000_0040, 16'd3, 16'd2, 16'd0, 16'd0, 1'b0, 2'd0, 16'd0};
        apply_cfg(v, 1'b0);
        start = 1'b1;
        @(negedge clk);
        cfg_base = 32'h0000_9999;
        cfg_icnt = 16'd50;
        for (int k = 0; k < 3; k++) begin
            chk(addr_valid == 1'b1 && addr == 32'h40, "R11 stall hold", addr, 32'h40);
            @(negedge clk);
        end
        start = 1'b0;
        advance = 1'b1;
        @(negedge clk);
        chk(addr == 32'h42, "R2 start ignored", addr, 32'h42);
        @(negedge clk);
        chk(addr == 32'h44, "R3 second step", addr, 32'h44);
        @(negedge clk);
        chk(irq_done == 1'b1, "R2 count not reloaded", 32'(irq_done), 32'd1);
        advance = 1'b0;
        @(negedge clk);

        // R8: circular restart
        v = '{32'h0000_0500, 16'd2, 16'd1, 16'd2, 16'd3, 1'b1, 2'd1, 16'd0};
        apply_cfg(v, 1'b1);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        walk(v, "R8 first buffer");
        @(negedge clk);
        chk(addr_valid == 1'b1 && addr == 32'h500, "R8 restart base", addr, 32'h500);
        chk(irq_done == 1'b0, "R8 done single cycle", 32'(irq_done), 32'd0);
        walk(v, "R8 second buffer");
        advance = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R1 reset stops circular", 32'(busy), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R6: zero count means 65536
        v = '{32'h0000_0000, 16'd0, 16'd1, 16'd0, 16'd0, 1'b0, 2'd0, 16'd0};
        run_single(v, "R6 full count");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule